// File: doc/BRIEF.md
# Stop Mode Control Unit

This block decides what happens when the processor executes a STOP instruction. It holds a small control register. The register has three stop-mode enables (fast clock, slow clock, no clock), of which at most one may be set at a time, plus one enable for an automatic move from slow-clock stop to fast-clock stop. When the processor raises its STOP request, the block does one of two things. If a mode enable is set, it parks in the matching low-power state and drives the oscillator mode outputs. If no enable is set, the STOP is illegal, and the block raises either an illegal-opcode reset request or an illegal-instruction exception request, chosen by an external configuration input.

Once parked, the block wakes on an interrupt. An ordinary pending interrupt wakes it from fast-clock stop and from slow-clock stop. Only the asynchronous wake interrupt, or a reset, wakes it from no-clock stop. A frame-start pulse that arrives during slow-clock stop, with the automatic-move enable set, brings the block to fast-clock stop without any processor action. This lets the sampling front end restart at full oscillator speed.

Top module: `stopmode_ctrl`

## Requirements
- R1: The mode enables sit at FC=bit 3, SC=bit 2, NC=bit 1 and the auto-move enable SCtoFC at bit 0. A write that sets at most one of FC, SC and NC stores all four bits. The read-back port shows the stored value in the cycle after the write. At most one of FC, SC and NC is ever set.
- R2: A write that sets two or three of FC, SC and NC clears all three. Bit 0 of that write is still stored as SCtoFC.
- R3: A STOP request in RUN with none of FC, SC and NC set leaves the power state at RUN (code 0).
- R4: An illegal STOP produces a one-cycle pulse in the next cycle: on the reset request when the IRD input is 0, or on the exception request when IRD is 1. It never produces both. Neither request pulses at any other time.
- R5: A STOP in RUN with FC set enters power state 1 (fast-clock stop) in the next cycle. The oscillator mode stays full speed (code 0).
- R6: A STOP in RUN with SC set enters power state 2 (slow-clock stop) in the next cycle. The oscillator mode is low speed (code 1).
- R7: A STOP in RUN with NC set enters power state 3 (no-clock stop) in the next cycle, with the oscillator off (code 2). The ordinary interrupt and frame-start have no effect there. Only the asynchronous interrupt or the synchronous reset leaves that state.
- R8: In power state 1 or 2, the ordinary interrupt or the asynchronous interrupt returns the block to RUN in the next cycle, with the oscillator at full speed. Waking takes priority over frame-start.
- R9: In power state 2 with SCtoFC set, a frame-start pulse with no interrupt moves the block to power state 1 in the next cycle.
- R10: A frame-start pulse has no effect in RUN, in power states 1 and 3, or in power state 2 when SCtoFC is 0.
- R11: The synchronous reset input clears all four register bits and returns the block to RUN in the next cycle. It overrides every other input in the same cycle. The asynchronous reset gives the same state.
- R12: A STOP request outside RUN is ignored. When a write and a STOP request arrive in the same cycle, the STOP decision uses the register value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset of register and state |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 4 | Register write value |
| cfg_rd_data | output | 4 | Register read-back value |
| stop_req | input | 1 | Processor is executing STOP (one cycle) |
| ird_cfg | input | 1 | Illegal STOP response: 0 reset, 1 exception |
| irq_pending | input | 1 | Enabled ordinary interrupt |
| async_irq | input | 1 | Asynchronous wake interrupt |
| frame_start | input | 1 | Start-of-sample-frame pulse |
| pwr_state | output | 2 | Power state: 0 RUN, 1 fast-clock stop, 2 slow-clock stop, 3 no-clock stop |
| osc_mode | output | 2 | Oscillator mode: 0 full speed, 1 low speed, 2 off |
| illegal_rst_req | output | 1 | Illegal-opcode reset request pulse |
| illegal_exc_req | output | 1 | Illegal-instruction exception request pulse |

## Verification
A corrupt enable set shows up on the read-back port one cycle after the offending write. It also shows up one cycle after the next STOP, as a wrong power state or a missing or extra illegal pulse. A state register that drifts shows on the power-state and oscillator outputs in the cycle it goes wrong. The two can never disagree, so a bad oscillator decode appears at once even while the state is correct. Wake and frame-start faults appear one cycle after the offending input, because every transition is a single registered step.

// File: rtl/stopmode_pkg.sv
package stopmode_pkg;
  localparam int CFG_W    = 4;
  localparam int BIT_FC   = 3;
  localparam int BIT_SC   = 2;
  localparam int BIT_NC   = 1;
  localparam int BIT_S2F  = 0;

  typedef enum logic [1:0] {
    PS_RUN     = 2'd0,
    PS_STOP_FC = 2'd1,
    PS_STOP_SC = 2'd2,
    PS_STOP_NC = 2'd3
  } pwr_state_e;

  typedef enum logic [1:0] {
    OSC_FULL = 2'd0,
    OSC_LOW  = 2'd1,
    OSC_OFF  = 2'd2
  } osc_mode_e;

  typedef struct packed {
    logic fc;
    logic sc;
    logic nc;
    logic s2f;
  } stop_cfg_t;
endpackage

// File: rtl/stopmode_cfg_reg.sv
module stopmode_cfg_reg
  import stopmode_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output stop_cfg_t     cfg_q,
  output logic [W-1:0]  rd_data
);
  localparam int MODE_CNT_W = 2;

  stop_cfg_t          cfg_d;
  logic               cfg_en;
  logic [MODE_CNT_W-1:0] mode_cnt;
  logic               conflict;

  always_comb begin
    mode_cnt = {1'b0, wr_data[BIT_FC]} + {1'b0, wr_data[BIT_SC]}
             + {1'b0, wr_data[BIT_NC]};
    conflict = (mode_cnt > 2'd1);
  end

  always_comb begin
    cfg_en = soft_rst | wr_en;
    cfg_d  = cfg_q;
    if (soft_rst) begin
      cfg_d = '0;
    end else if (wr_en) begin
      cfg_d.s2f = wr_data[BIT_S2F];
      if (conflict) begin
        cfg_d.fc = 1'b0;
        cfg_d.sc = 1'b0;
        cfg_d.nc = 1'b0;
      end else begin
        cfg_d.fc = wr_data[BIT_FC];
        cfg_d.sc = wr_data[BIT_SC];
        cfg_d.nc = wr_data[BIT_NC];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    rd_data          = '0;
    rd_data[BIT_FC]  = cfg_q.fc;
    rd_data[BIT_SC]  = cfg_q.sc;
    rd_data[BIT_NC]  = cfg_q.nc;
    rd_data[BIT_S2F] = cfg_q.s2f;
  end
endmodule

// File: rtl/stopmode_fsm.sv
module stopmode_fsm
  import stopmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  stop_cfg_t  cfg,
  input  logic       stop_req,
  input  logic       ird_cfg,
  input  logic       irq_pending,
  input  logic       async_irq,
  input  logic       frame_start,
  output pwr_state_e state_q,
  output pwr_state_e state_d,
  output logic       rst_pulse_q,
  output logic       exc_pulse_q
);
  logic illegal_stop;
  logic rst_pulse_d;
  logic exc_pulse_d;
  logic wake_any;

  always_comb begin
    wake_any     = irq_pending | async_irq;
    illegal_stop = (state_q == PS_RUN) && stop_req && !(cfg.fc | cfg.sc | cfg.nc);
    state_d      = state_q;
    if (soft_rst) begin
      state_d = PS_RUN;
    end else begin
      unique case (state_q)
        PS_RUN: begin
          if (stop_req) begin
            if (cfg.fc)      state_d = PS_STOP_FC;
            else if (cfg.sc) state_d = PS_STOP_SC;
            else if (cfg.nc) state_d = PS_STOP_NC;
          end
        end
        PS_STOP_FC: begin
          if (wake_any) state_d = PS_RUN;
        end
        PS_STOP_SC: begin
          if (wake_any)                   state_d = PS_RUN;
          else if (frame_start && cfg.s2f) state_d = PS_STOP_FC;
        end
        PS_STOP_NC: begin
          if (async_irq) state_d = PS_RUN;
        end
        default: state_d = PS_RUN;
      endcase
    end
    rst_pulse_d = !soft_rst && illegal_stop && !ird_cfg;
    exc_pulse_d = !soft_rst && illegal_stop &&  ird_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PS_RUN;
      rst_pulse_q <= 1'b0;
      exc_pulse_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      rst_pulse_q <= rst_pulse_d;
      exc_pulse_q <= exc_pulse_d;
    end
  end
endmodule

// File: rtl/stopmode_osc_dec.sv
module stopmode_osc_dec
  import stopmode_pkg::*;
#(
  parameter bit OSC_REGISTERED = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_e state_q,
  input  pwr_state_e state_d,
  output osc_mode_e  osc_mode
);
  function automatic osc_mode_e map_osc(input pwr_state_e s);
    unique case (s)
      PS_STOP_SC: map_osc = OSC_LOW;
      PS_STOP_NC: map_osc = OSC_OFF;
      default:    map_osc = OSC_FULL;
    endcase
  endfunction

  generate
    if (OSC_REGISTERED) begin : g_reg
      osc_mode_e osc_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) osc_q <= OSC_FULL;
        else        osc_q <= map_osc(state_d);
      end
      assign osc_mode = osc_q;
      logic unused_q;
      assign unused_q = ^state_q;
    end else begin : g_comb
      assign osc_mode = map_osc(state_q);
      logic unused_d;
      assign unused_d = ^{state_d, clk, rst_n};
    end
  endgenerate
endmodule

// File: rtl/stopmode_ctrl.sv
module stopmode_ctrl
  import stopmode_pkg::*;
#(
  parameter bit OSC_REGISTERED = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  output logic [CFG_W-1:0] cfg_rd_data,
  input  logic             stop_req,
  input  logic             ird_cfg,
  input  logic             irq_pending,
  input  logic             async_irq,
  input  logic             frame_start,
  output logic [1:0]       pwr_state,
  output logic [1:0]       osc_mode,
  output logic             illegal_rst_req,
  output logic             illegal_exc_req
);
  stop_cfg_t  cfg_q;
  pwr_state_e st_q;
  pwr_state_e st_d;
  osc_mode_e  osc;

  stopmode_cfg_reg #(.W(CFG_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .cfg_q   (cfg_q),
    .rd_data (cfg_rd_data)
  );

  stopmode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .cfg        (cfg_q),
    .stop_req   (stop_req),
    .ird_cfg    (ird_cfg),
    .irq_pending(irq_pending),
    .async_irq  (async_irq),
    .frame_start(frame_start),
    .state_q    (st_q),
    .state_d    (st_d),
    .rst_pulse_q(illegal_rst_req),
    .exc_pulse_q(illegal_exc_req)
  );

  stopmode_osc_dec #(.OSC_REGISTERED(OSC_REGISTERED)) u_osc (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_q (st_q),
    .state_d (st_d),
    .osc_mode(osc)
  );

  assign pwr_state = st_q;
  assign osc_mode  = osc;
endmodule

// File: rtl/stopmode_ctrl_chk.sv
module stopmode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       cfg_wr_en,
  input logic [3:0] cfg_wr_data,
  input logic [3:0] cfg_rd_data,
  input logic       stop_req,
  input logic       ird_cfg,
  input logic       irq_pending,
  input logic       async_irq,
  input logic       frame_start,
  input logic [1:0] pwr_state,
  input logic [1:0] osc_mode,
  input logic       illegal_rst_req,
  input logic       illegal_exc_req
);
  AST_ENABLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cfg_rd_data[3:1]) <= 1); // R1

  AST_MULTI_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && !soft_rst && $countones(cfg_wr_data[3:1]) > 1)
    |=> (cfg_rd_data[3:1] == 3'b000)); // R2

  AST_ILLEGAL_STAYS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0 && stop_req && cfg_rd_data[3:1] == 3'b000 && !soft_rst)
    |=> (pwr_state == 2'd0)); // R3

  AST_ILLEGAL_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0 && stop_req && cfg_rd_data[3:1] == 3'b000 && !soft_rst)
    |=> (illegal_exc_req == $past(ird_cfg) && illegal_rst_req == !$past(ird_cfg))); // R4

  AST_REQ_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal_rst_req && illegal_exc_req)); // R4

  AST_RST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_rst_req |=> !illegal_rst_req); // R4

  AST_EXC_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_exc_req |=> !illegal_exc_req); // R4

  AST_OSC_MATCHES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd3) == (osc_mode == 2'd2)); // R7

  AST_NC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd3 && !async_irq && !soft_rst) |=> (pwr_state == 2'd3)); // R7

  AST_WAKE_FC: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd1 && (irq_pending || async_irq)) |=> (pwr_state == 2'd0)); // R8

  AST_FRAME_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd2 && frame_start && cfg_rd_data[0] && !irq_pending
     && !async_irq && !soft_rst) |=> (pwr_state == 2'd1)); // R9

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (pwr_state == 2'd0 && cfg_rd_data == 4'd0)); // R11
endmodule

bind stopmode_ctrl stopmode_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .soft_rst       (soft_rst),
  .cfg_wr_en      (cfg_wr_en),
  .cfg_wr_data    (cfg_wr_data),
  .cfg_rd_data    (cfg_rd_data),
  .stop_req       (stop_req),
  .ird_cfg        (ird_cfg),
  .irq_pending    (irq_pending),
  .async_irq      (async_irq),
  .frame_start    (frame_start),
  .pwr_state      (pwr_state),
  .osc_mode       (osc_mode),
  .illegal_rst_req(illegal_rst_req),
  .illegal_exc_req(illegal_exc_req)
);

// File: tb/stopmode_ctrl_test.sv
module stopmode_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [3:0] cfg_wr_data = 4'd0;
  logic [3:0] cfg_rd_data;
  logic       stop_req = 1'b0;
  logic       ird_cfg = 1'b0;
  logic       irq_pending = 1'b0;
  logic       async_irq = 1'b0;
  logic       frame_start = 1'b0;
  logic [1:0] pwr_state;
  logic [1:0] osc_mode;
  logic       illegal_rst_req;
  logic       illegal_exc_req;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;
  string cur_req = "R11";

  // behavioural reference model
  int m_fc, m_sc, m_nc, m_s2f, m_state, m_rp, m_ep;

  always #(CLK_PERIOD/2) clk = ~clk;

  stopmode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .stop_req(stop_req), .ird_cfg(ird_cfg), .irq_pending(irq_pending),
    .async_irq(async_irq), .frame_start(frame_start),
    .pwr_state(pwr_state), .osc_mode(osc_mode),
    .illegal_rst_req(illegal_rst_req), .illegal_exc_req(illegal_exc_req)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fc = 0; m_sc = 0; m_nc = 0; m_s2f = 0; m_state = 0; m_rp = 0; m_ep = 0;
    end else begin
      m_rp = 0; m_ep = 0;
      if (soft_rst) begin
        m_fc = 0; m_sc = 0; m_nc = 0; m_s2f = 0; m_state = 0;
      end else begin
        if (m_state == 0) begin
          if (stop_req) begin
            if (m_fc != 0)      m_state = 1;
            else if (m_sc != 0) m_state = 2;
            else if (m_nc != 0) m_state = 3;
            else if (ird_cfg)   m_ep = 1;
            else                m_rp = 1;
          end
        end else if (m_state == 1) begin
          if (irq_pending || async_irq) m_state = 0;
        end else if (m_state == 2) begin
          if (irq_pending || async_irq) m_state = 0;
          else if (frame_start && m_s2f != 0) m_state = 1;
        end else begin
          if (async_irq) m_state = 0;
        end
        if (cfg_wr_en) begin
          m_s2f = cfg_wr_data[0];
          if (int'(cfg_wr_data[3]) + int'(cfg_wr_data[2]) + int'(cfg_wr_data[1]) > 1) begin
            m_fc = 0; m_sc = 0; m_nc = 0;
          end else begin
            m_fc = cfg_wr_data[3]; m_sc = cfg_wr_data[2]; m_nc = cfg_wr_data[1];
          end
        end
      end
    end
  end

  function automatic int exp_osc(input int s);
    if (s == 2) return 1;
    if (s == 3) return 2;
    return 0;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "pwr_state", int'(pwr_state), m_state);
      check(cur_req, "osc_mode", int'(osc_mode), exp_osc(m_state));
      check(cur_req, "cfg_rd_data", int'(cfg_rd_data), m_fc*8 + m_sc*4 + m_nc*2 + m_s2f);
      check(cur_req, "illegal_rst_req", int'(illegal_rst_req), m_rp);
      check(cur_req, "illegal_exc_req", int'(illegal_exc_req), m_ep);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES && !done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] d);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    tick();
    cfg_wr_en = 1'b0; cfg_wr_data = 4'd0;
  endtask

  task automatic stop();
    stop_req = 1'b1;
    tick();
    stop_req = 1'b0;
  endtask

  task automatic irq();
    irq_pending = 1'b1;
    tick();
    irq_pending = 1'b0;
  endtask

  task automatic frame();
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    cur_req = "R11";
    check("R11", "reset pwr_state", int'(pwr_state), 0);
    check("R11", "reset cfg_rd_data", int'(cfg_rd_data), 0);

    cur_req = "R1";
    wr(4'b1000);
    check("R1", "FC readback", int'(cfg_rd_data), 8);
    cur_req = "R5";
    stop();
    check("R5", "FC stop state", int'(pwr_state), 1);
    check("R5", "FC stop osc", int'(osc_mode), 0);
    cur_req = "R12";
    stop();
    check("R12", "stop outside RUN", int'(pwr_state), 1);
    cur_req = "R10";
    frame();
    check("R10", "frame in FC stop", int'(pwr_state), 1);
    cur_req = "R8";
    irq();
    check("R8", "wake from FC", int'(pwr_state), 0);

    cur_req = "R6";
    wr(4'b0100);
    stop();
    check("R6", "SC stop state", int'(pwr_state), 2);
    check("R6", "SC stop osc", int'(osc_mode), 1);
    cur_req = "R10";
    frame();
    check("R10", "frame with SCtoFC=0", int'(pwr_state), 2);
    cur_req = "R8";
    async_irq = 1'b1; tick(); async_irq = 1'b0;
    check("R8", "async wake from SC", int'(pwr_state), 0);

    cur_req = "R9";
    wr(4'b0101);
    check("R1", "SC+SCtoFC readback", int'(cfg_rd_data), 5);
    stop();
    frame();
    check("R9", "frame moves SC to FC", int'(pwr_state), 1);
    check("R9", "osc after move", int'(osc_mode), 0);
    irq();
    cur_req = "R8";
    stop();
    frame_start = 1'b1; irq_pending = 1'b1; tick();
    frame_start = 1'b0; irq_pending = 1'b0;
    check("R8", "wake beats frame", int'(pwr_state), 0);
    cur_req = "R10";
    frame();
    check("R10", "frame in RUN", int'(pwr_state), 0);

    cur_req = "R7";
    wr(4'b0010);
    stop();
    check("R7", "NC stop state", int'(pwr_state), 3);
    check("R7", "NC osc off", int'(osc_mode), 2);
    irq();
    check("R7", "irq ignored in NC", int'(pwr_state), 3);
    frame();
    check("R7", "frame ignored in NC", int'(pwr_state), 3);
    async_irq = 1'b1; tick(); async_irq = 1'b0;
    check("R7", "async wake from NC", int'(pwr_state), 0);

    cur_req = "R2";
    wr(4'b1100);
    check("R2", "two enables cleared", int'(cfg_rd_data), 0);
    wr(4'b1111);
    check("R2", "three enables cleared, SCtoFC kept", int'(cfg_rd_data), 1);
    wr(4'b1010);
    check("R2", "FC+NC cleared", int'(cfg_rd_data), 0);

    cur_req = "R3";
    ird_cfg = 1'b0;
    stop();
    check("R3", "illegal stays RUN", int'(pwr_state), 0);
    check("R4", "reset request", int'(illegal_rst_req), 1);
    check("R4", "no exception", int'(illegal_exc_req), 0);
    tick();
    check("R4", "reset pulse ends", int'(illegal_rst_req), 0);
    cur_req = "R4";
    ird_cfg = 1'b1;
    stop();
    check("R4", "exception request", int'(illegal_exc_req), 1);
    check("R4", "no reset", int'(illegal_rst_req), 0);
    tick();
    check("R4", "exception pulse ends", int'(illegal_exc_req), 0);
    ird_cfg = 1'b0;

    cur_req = "R12";
    wr(4'b1000);
    stop_req = 1'b1; cfg_wr_en = 1'b1; cfg_wr_data = 4'b0100; tick();
    stop_req = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = 4'd0;
    check("R12", "stop uses old value", int'(pwr_state), 1);
    check("R12", "write still lands", int'(cfg_rd_data), 4);
    irq();

    cur_req = "R11";
    wr(4'b0101);
    stop();
    soft_rst = 1'b1; frame_start = 1'b1; cfg_wr_en = 1'b1; cfg_wr_data = 4'b1000;
    tick();
    soft_rst = 1'b0; frame_start = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = 4'd0;
    check("R11", "soft reset to RUN", int'(pwr_state), 0);
    check("R11", "soft reset clears register", int'(cfg_rd_data), 0);
    stop_req = 1'b1; soft_rst = 1'b1; tick();
    stop_req = 1'b0; soft_rst = 1'b0;
    check("R11", "soft reset masks illegal pulse", int'(illegal_rst_req), 0);

    repeat (2) tick();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule